// File: doc/BRIEF.md
# Quasi-Bidirectional Port with High-Address Override

This block models one 8-bit general-purpose port whose pins have a fixed internal weak pull-up and a switchable pull-down. In normal operation the CPU writes a byte into an output latch. A latch bit of 0 pulls its pin low. A latch bit of 1 releases the pin, so the weak pull-up holds it high unless something outside pulls it down. Writing 1 to a bit therefore turns that bit into an input.

A single mode select hands the whole byte to the external-memory address path. While it is asserted, all eight pins show the high address byte. The latch is left alone during that time, and the pins go back to the latch contents when the mode ends. CPU writes made during address mode still update the latch. They reach the pins only after address mode ends.

The port reports two values back. One is the latch contents. The other is the resolved pin level, passed through a configurable synchroniser of zero to three stages.

Top module: `qbd_port`

## Requirements
- R1: After reset the latch reads 0xFF, every pull-down enable is 0, every weak pull-up enable is 1, and the pin readback is 0xFF while no outside source pulls low.
- R2: With address mode off, a latch bit of 0 makes its pull-down enable 1 and its weak pull-up enable 0.
- R3: With address mode off, a latch bit of 1 makes its pull-down enable 0 and its weak pull-up enable 1.
- R4: The pin readback bit is 1 exactly when the pin's pull-down enable is 0 and no outside source pulls that pin low (`ext_pull_low` bit 0). The readback appears SYNC_STAGES clock edges after the pin level changes (default 2).
- R5: With address mode on (`addr_mode` = 1), every pin follows the address byte at once: pull-down enable bit i equals the inverse of `addr_hi` bit i, and the pull-up enable equals `addr_hi`.
- R6: The latch changes only on a clock edge with `wr_en` = 1. Entering and leaving address mode leaves it unchanged, and after address mode ends the pins follow the latch again.
- R7: A write (`wr_en` = 1) stores `wr_data` at the next clock edge, also during address mode. In address mode the written value shows on the latch readback but not on the pins.
- R8: At all times the weak pull-up enable of each bit is the inverse of its pull-down enable.

Bit i of every bus belongs to pin i. No bit order or code other than this is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU latch write strobe |
| wr_data | input | WIDTH | CPU write data |
| addr_mode | input | 1 | 1: pins show the high address byte |
| addr_hi | input | WIDTH | High address byte (A8..A15) |
| ext_pull_low | input | WIDTH | Per-pin outside source pulling the pin low |
| pull_dn_en | output | WIDTH | Per-pin pull-down enable |
| weak_pu_en | output | WIDTH | Per-pin weak pull-up enable |
| pin_rd | output | WIDTH | Synchronised resolved pin level |
| latch_rd | output | WIDTH | Latch contents |

## Verification
The clocked assertions take two things for granted. The write strobe, write data, mode select and address byte are stable and known around each rising edge. Write and mode select are held low while reset is asserted, so that no write capture is expected from a reset cycle. The stimulus follows these rules by changing every input only on the falling clock edge and by keeping all control inputs at 0 until reset has been released. The synchroniser's pin-readback latency is handled by waiting the configured number of edges before each sample, rather than being assumed away.

// File: rtl/qbd_pkg.sv
package qbd_pkg;
   localparam int unsigned QBD_MAX_SYNC = 3;

   typedef enum logic {
      QBD_SRC_LATCH = 1'b0,
      QBD_SRC_ADDR  = 1'b1
   } qbd_src_e;

   // Resolved pin level: strong low wins, otherwise weak high unless pulled outside.
   function automatic logic qbd_resolve(input logic pd, input logic ext_low);
      return ~pd & ~ext_low;
   endfunction
endpackage

// File: rtl/qbd_latch.sv
module qbd_latch #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] latch_q
);
   localparam logic [WIDTH-1:0] RST_VAL = {WIDTH{1'b1}};

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("qbd_latch: WIDTH must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         latch_q <= RST_VAL;
      else if (wr_en)
         latch_q <= wr_data;
   end

   AST_WR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> latch_q == $past(wr_data)); // R7

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(latch_q)); // R6
endmodule

// File: rtl/qbd_drive.sv
module qbd_drive #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] latch_q,
   input  logic             addr_mode,
   input  logic [WIDTH-1:0] addr_hi,
   input  logic [WIDTH-1:0] ext_pull_low,
   output logic [WIDTH-1:0] pull_dn_en,
   output logic [WIDTH-1:0] weak_pu_en,
   output logic [WIDTH-1:0] pin_level
);
   import qbd_pkg::*;

   qbd_src_e src;
   assign src = addr_mode ? QBD_SRC_ADDR : QBD_SRC_LATCH;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic level_sel;
         always_comb begin
            unique case (src)
               QBD_SRC_ADDR:  level_sel = addr_hi[i];
               default:       level_sel = latch_q[i];
            endcase
         end
         assign pull_dn_en[i] = ~level_sel;
         assign weak_pu_en[i] = level_sel;
         assign pin_level[i]  = qbd_resolve(pull_dn_en[i], ext_pull_low[i]);
      end
   endgenerate

   AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      addr_mode |-> (pull_dn_en == ~addr_hi)); // R5

   AST_LATCH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_mode |-> (weak_pu_en == latch_q)); // R2

   AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (pull_dn_en & weak_pu_en) == '0); // R8

   AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_level & pull_dn_en) == '0); // R4
endmodule

// File: rtl/qbd_pin_sync.sv
module qbd_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_level,
   output logic [WIDTH-1:0] pin_rd
);
   localparam logic [WIDTH-1:0] IDLE_VAL = {WIDTH{1'b1}};

   generate
      if (STAGES > qbd_pkg::QBD_MAX_SYNC) begin : g_bad_stages
         $error("qbd_pin_sync: STAGES exceeds QBD_MAX_SYNC");
      end

      if (STAGES == 0) begin : g_comb
         assign pin_rd = pin_level;
      end else begin : g_reg
         logic [WIDTH-1:0] stage_q [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stage_q[s] <= IDLE_VAL;
            end else begin
               stage_q[0] <= pin_level;
               for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
            end
         end
         assign pin_rd = stage_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/qbd_port.sv
module qbd_port #(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             addr_mode,
   input  logic [WIDTH-1:0] addr_hi,
   input  logic [WIDTH-1:0] ext_pull_low,
   output logic [WIDTH-1:0] pull_dn_en,
   output logic [WIDTH-1:0] weak_pu_en,
   output logic [WIDTH-1:0] pin_rd,
   output logic [WIDTH-1:0] latch_rd
);
   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_level;

   qbd_latch #(.WIDTH(WIDTH)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .latch_q (latch_q)
   );

   qbd_drive #(.WIDTH(WIDTH)) u_drive (
      .clk          (clk),
      .rst_n        (rst_n),
      .latch_q      (latch_q),
      .addr_mode    (addr_mode),
      .addr_hi      (addr_hi),
      .ext_pull_low (ext_pull_low),
      .pull_dn_en   (pull_dn_en),
      .weak_pu_en   (weak_pu_en),
      .pin_level    (pin_level)
   );

   qbd_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_level (pin_level),
      .pin_rd    (pin_rd)
   );

   assign latch_rd = latch_q;

   AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(addr_mode) && !addr_mode) |-> (pull_dn_en == ~latch_rd)); // R6
endmodule

// File: tb/qbd_port_bench.sv
module qbd_port_bench;
   localparam int W = 8;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic addr_mode = 1'b0;
   logic [W-1:0] addr_hi = '0;
   logic [W-1:0] ext_pull_low = '0;
   logic [W-1:0] pull_dn_en, weak_pu_en, pin_rd, latch_rd;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   qbd_port #(.WIDTH(W), .SYNC_STAGES(SYNC)) u_qbd_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .addr_mode(addr_mode), .addr_hi(addr_hi), .ext_pull_low(ext_pull_low),
      .pull_dn_en(pull_dn_en), .weak_pu_en(weak_pu_en),
      .pin_rd(pin_rd), .latch_rd(latch_rd)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // One write; returns at the falling edge after the capturing rising edge.
   task automatic write_latch(input logic [W-1:0] v);
      wr_data = v;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_sync();
      repeat (SYNC) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 latch", latch_rd, 8'hFF);
      chk("R1 pulldown", pull_dn_en, 8'h00);
      chk("R1 pullup", weak_pu_en, 8'hFF);
      chk("R1 pin", pin_rd, 8'hFF);

      // R2/R3/R8/R4 sweep of all latch values with several outside patterns
      for (int v = 0; v < 256; v++) begin
         logic [W-1:0] ext;
         ext = W'((v * 37) ^ 8'h5A);
         ext_pull_low = ext;
         write_latch(W'(v));
         chk("R7 latch capture", latch_rd, W'(v));
         chk("R2 pulldown from latch", pull_dn_en, ~W'(v));
         chk("R3 pullup from latch", weak_pu_en, W'(v));
         chk("R8 complementary", weak_pu_en, ~pull_dn_en);
         wait_sync();
         chk("R4 pin level", pin_rd, W'(v) & ~ext);
      end

      // R4: input use after writing 1s
      ext_pull_low = '0;
      write_latch(8'hFF);
      wait_sync();
      chk("R4 released pins idle high", pin_rd, 8'hFF);
      ext_pull_low = 8'hA5;
      @(negedge clk);
      wait_sync();
      chk("R4 outside pull low seen", pin_rd, 8'h5A);

      // R5/R6: address sweep, latch preserved
      ext_pull_low = '0;
      write_latch(8'h3C);
      addr_mode = 1'b1;
      for (int a = 0; a < 256; a++) begin
         addr_hi = W'(a);
         @(negedge clk);
         chk("R5 pulldown from address", pull_dn_en, ~W'(a));
         chk("R5 pullup from address", weak_pu_en, W'(a));
         chk("R6 latch held in address mode", latch_rd, 8'h3C);
      end
      addr_hi = 8'h81;
      @(negedge clk);
      wait_sync();
      chk("R5 pin follows address", pin_rd, 8'h81);
      addr_mode = 1'b0;
      @(negedge clk);
      chk("R6 pins return to latch", pull_dn_en, ~8'h3C);
      chk("R6 latch unchanged after exit", latch_rd, 8'h3C);

      // R7: write during address mode
      addr_mode = 1'b1;
      addr_hi = 8'hF0;
      write_latch(8'h96);
      chk("R7 latch written in address mode", latch_rd, 8'h96);
      chk("R7 pins keep address", pull_dn_en, 8'h0F);
      wait_sync();
      chk("R7 pin readback keeps address", pin_rd, 8'hF0);
      addr_mode = 1'b0;
      @(negedge clk);
      chk("R7 written value reaches pins", pull_dn_en, 8'h69);
      wait_sync();
      chk("R7 pin readback after exit", pin_rd, 8'h96);

      // R6: idle cycles without write keep latch
      repeat (5) @(negedge clk);
      chk("R6 latch idle hold", latch_rd, 8'h96);

      // R1: reset mid-run restores defaults
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 latch after second reset", latch_rd, 8'hFF);
      chk("R1 pin after second reset", pin_rd, 8'hFF);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule